// File: doc/BRIEF.md
# Power-up strap latch controller

This block runs a pin that is both a configuration strap and a clock output. When the supply crosses its threshold, a power-good input rises and a sampling window opens. The window is timed in cycles of a free-running reference clock. For the whole window the pin's output driver stays disabled, so an external pull resistor alone sets the pin level. The block watches that level through a synchronizer.

When the window closes, the level is frozen into a configuration bit. A low level gives 0 and a high level gives 1. The driver is then enabled and the pin carries a supplied unmodulated clock for the rest of operation. Only a loss of power-good clears the frozen bit. The bit selects the spread depth while an active-low spread enable input is low: 0 selects the narrow 1.25% setting and 1 selects the wide 3.75% setting.

The output enable and the clock gate move only on falling edges of the supplied clock. Because of this, the first pulse driven onto the pin is never shortened.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While pwr_good is low, pad_oe, pad_out, strap_valid, strap_bit, spread_on and spread_wide are all 0.
- R2: strap_valid rises on rising ref_clk edge number WIN_CYCLES+2 after pwr_good rises, counting the first edge after the rise as 1. It is 0 on every earlier edge and then stays 1.
- R3: Until strap_valid is 1, pad_oe is 0 and pad_out is 0.
- R4: strap_bit takes the level of pad_in on the closing edge through a two-flop synchronizer. A low level gives 0 and a high level gives 1, provided pad_in is held for at least two ref_clk cycles before that edge.
- R5: After strap_valid is 1, changes on pad_in have no effect on strap_bit.
- R6: pad_oe rises by the second falling edge of clk_src after strap_valid rises. While pwr_good is high it changes only while clk_src is low. Once pad_oe is 1, pad_out equals clk_src.
- R7: A fall of pwr_good clears all outputs at once, without waiting for a clock edge. A new rise of pwr_good runs a fresh window and may latch a different bit.
- R8: spread_on is 1 only when strap_valid is 1 and spread_en_n is 0. spread_wide is spread_on AND strap_bit, where 1 means 3.75% and 0 means 1.25%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that times the window |
| pwr_good | input | 1 | Supply above threshold; low acts as an asynchronous clear |
| pad_in | input | 1 | Level read back from the dual-purpose pin |
| clk_src | input | 1 | Unmodulated clock to drive onto the pin after the window |
| spread_en_n | input | 1 | Active-low spread enable |
| pad_oe | output | 1 | Pin output driver enable (0 = high impedance) |
| pad_out | output | 1 | Gated clock toward the pin driver |
| strap_valid | output | 1 | Window has closed and the strap bit is frozen |
| strap_bit | output | 1 | Frozen configuration bit |
| spread_on | output | 1 | Spread modulation active |
| spread_wide | output | 1 | Wide spread selected (1 = 3.75%, 0 = 1.25%) |

## Verification
strap_valid is due on the rising ref_clk edge WIN_CYCLES+2 after pwr_good rises: two edges go to the reset synchronizer, then WIN_CYCLES counting edges follow. The bench raises pwr_good on a falling edge and counts rising edges from there. It samples on the falling edge after edge WIN_CYCLES+1, expecting 0, and on the falling edge after the next rising edge, expecting 1 together with the pad level as strap_bit.

pad_oe crosses into the clk_src domain over two falling edges, so the bench waits three falling edges before checking it. It then samples pad_out one time unit after each clk_src edge. A monitor flags any change of pad_oe seen while clk_src is high with power good.

The power-loss clear is combinational, and so are the spread outputs. Both are checked one time unit after their input changes.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [0:0] {
    WIN_OPEN   = 1'b0,
    WIN_LOCKED = 1'b1
  } win_state_e;
endpackage

// File: rtl/strap_sync.sv
// Multi-stage synchronizer with asynchronous active-low clear.
module strap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/strap_window.sv
// Window timer and strap capture in the reference domain.
module strap_window
  import strap_pkg::*;
#(
  parameter int WIN_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_s,
  output logic locked,
  output logic bit_q
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  win_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             lock_ev;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    lock_ev = 1'b0;
    case (state_q)
      WIN_OPEN: begin
        if (cnt_q == LAST) begin
          lock_ev = 1'b1;
          state_d = WIN_LOCKED;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = WIN_LOCKED;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_OPEN;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (lock_ev) begin
      bit_q <= pad_s;
    end
  end

  assign locked = (state_q == WIN_LOCKED);
endmodule

// File: rtl/strap_out_gate.sv
// Carries the enable request into the clk_src domain on falling edges
// and gates the clock, so gate changes happen only while clk_src is low.
module strap_out_gate #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic req,
  output logic oe,
  output logic clk_out
);
  logic [STAGES-1:0] en_q;
  logic [STAGES-1:0] en_d;

  always_comb begin
    en_d = {en_q[STAGES-2:0], req};
  end

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  assign oe      = en_q[STAGES-1];
  assign clk_out = clk_src & oe;
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl #(
  parameter int WIN_CYCLES  = 28636,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic pwr_good,
  input  logic pad_in,
  input  logic clk_src,
  input  logic spread_en_n,
  output logic pad_oe,
  output logic pad_out,
  output logic strap_valid,
  output logic strap_bit,
  output logic spread_on,
  output logic spread_wide
);
  logic rst_n_sync;
  logic pad_s;
  logic locked;
  logic bit_q;

  strap_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (ref_clk),
    .rst_n (pwr_good),
    .d     (1'b1),
    .q     (rst_n_sync)
  );

  strap_sync #(.STAGES(SYNC_STAGES)) u_pad_sync (
    .clk   (ref_clk),
    .rst_n (rst_n_sync),
    .d     (pad_in),
    .q     (pad_s)
  );

  strap_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk    (ref_clk),
    .rst_n  (rst_n_sync),
    .pad_s  (pad_s),
    .locked (locked),
    .bit_q  (bit_q)
  );

  strap_out_gate #(.STAGES(SYNC_STAGES)) u_gate (
    .clk_src (clk_src),
    .rst_n   (rst_n_sync),
    .req     (locked),
    .oe      (pad_oe),
    .clk_out (pad_out)
  );

  assign strap_valid = locked;
  assign strap_bit   = bit_q;
  assign spread_on   = locked & ~spread_en_n;
  assign spread_wide = locked & ~spread_en_n & bit_q;
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk #(
  parameter int WIN_CYCLES = 28636
) (
  input logic ref_clk,
  input logic rst_n,
  input logic strap_valid,
  input logic strap_bit,
  input logic pad_oe
);
  localparam int CW = $clog2(WIN_CYCLES + 2);
  localparam logic [CW-1:0] CMAX = CW'(WIN_CYCLES + 1);
  localparam logic [CW-1:0] CWIN = CW'(WIN_CYCLES);

  logic [CW-1:0] chk_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt <= '0;
    end else if (chk_cnt != CMAX) begin
      chk_cnt <= chk_cnt + 1'b1;
    end
  end

  AST_NOT_EARLY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    strap_valid |-> (chk_cnt >= CWIN)); // R2
  AST_NOT_LATE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !strap_valid |-> (chk_cnt <= CWIN)); // R2
  AST_VALID_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    strap_valid |=> strap_valid); // R2
  AST_DRIVER_OFF: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !strap_valid |-> !pad_oe); // R3
  AST_BIT_FROZEN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (strap_valid && $past(strap_valid)) |-> $stable(strap_bit)); // R5
endmodule

bind strap_latch_ctrl strap_latch_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .ref_clk     (ref_clk),
  .rst_n       (rst_n_sync),
  .strap_valid (strap_valid),
  .strap_bit   (strap_bit),
  .pad_oe      (pad_oe)
);

// File: tb/sim_strap_latch_ctrl.sv
`timescale 1ns/1ps
module sim_strap_latch_ctrl;
  localparam int WIN = 20;

  logic ref_clk = 1'b0;
  logic clk_src = 1'b0;
  logic pwr_good, pad_in, spread_en_n;
  logic pad_oe, pad_out, strap_valid, strap_bit, spread_on, spread_wide;
  int checks = 0;
  int failures = 0;

  always #4 ref_clk = ~ref_clk;
  always #5 clk_src = ~clk_src;

  strap_latch_ctrl #(.WIN_CYCLES(WIN)) u0 (
    .ref_clk(ref_clk), .pwr_good(pwr_good), .pad_in(pad_in),
    .clk_src(clk_src), .spread_en_n(spread_en_n), .pad_oe(pad_oe),
    .pad_out(pad_out), .strap_valid(strap_valid), .strap_bit(strap_bit),
    .spread_on(spread_on), .spread_wide(spread_wide)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // R6: the enable may only move while clk_src is low
  always @(pad_oe) begin
    if (pwr_good === 1'b1) begin
      checks++;
      if (clk_src !== 1'b0) begin
        failures++;
        $display("FAIL R6 pad_oe moved with clk_src actual=%b expected=0", clk_src);
      end
    end
  end

  task automatic t_reset();
    #20;
    check("R1 pad_oe", pad_oe, 1'b0);
    check("R1 pad_out", pad_out, 1'b0);
    check("R1 strap_valid", strap_valid, 1'b0);
    check("R1 strap_bit", strap_bit, 1'b0);
    check("R1 spread_on", spread_on, 1'b0);
  endtask

  task automatic t_window(input logic lvl);
    pad_in = lvl;
    @(negedge ref_clk) pwr_good = 1'b1;
    repeat (WIN / 2) @(posedge ref_clk);
    @(negedge ref_clk);
    check("R3 pad_oe mid-window", pad_oe, 1'b0);
    check("R3 pad_out mid-window", pad_out, 1'b0);
    check("R8 spread_on before lock", spread_on, 1'b0);
    repeat (WIN + 1 - WIN / 2) @(posedge ref_clk);
    @(negedge ref_clk);
    check("R2 valid one edge early", strap_valid, 1'b0);
    check("R3 pad_oe before lock", pad_oe, 1'b0);
    @(posedge ref_clk);
    @(negedge ref_clk);
    check("R2 valid on closing edge", strap_valid, 1'b1);
    check("R4 strap_bit", strap_bit, lvl);
  endtask

  task automatic t_clock_out();
    repeat (3) @(negedge clk_src);
    #1 check("R6 pad_oe enabled", pad_oe, 1'b1);
    @(posedge clk_src);
    #1 check("R6 pad_out high", pad_out, 1'b1);
    @(negedge clk_src);
    #1 check("R6 pad_out low", pad_out, 1'b0);
  endtask

  task automatic t_frozen();
    logic keep;
    keep = strap_bit;
    pad_in = ~keep;
    repeat (10) @(posedge ref_clk);
    @(negedge ref_clk);
    check("R5 strap_bit held", strap_bit, keep);
    check("R5 pad_oe held", pad_oe, 1'b1);
    pad_in = keep;
  endtask

  task automatic t_spread();
    spread_en_n = 1'b0;
    #1;
    check("R8 spread_on enabled", spread_on, 1'b1);
    check("R8 spread_wide", spread_wide, strap_bit);
    spread_en_n = 1'b1;
    #1;
    check("R8 spread_on disabled", spread_on, 1'b0);
    check("R8 spread_wide disabled", spread_wide, 1'b0);
    spread_en_n = 1'b0;
    #1;
  endtask

  task automatic t_power_loss();
    @(posedge clk_src);
    #1 pwr_good = 1'b0;
    #1;
    check("R7 strap_valid cleared", strap_valid, 1'b0);
    check("R7 strap_bit cleared", strap_bit, 1'b0);
    check("R7 pad_oe cleared", pad_oe, 1'b0);
    check("R7 pad_out cleared", pad_out, 1'b0);
    check("R7 spread_on cleared", spread_on, 1'b0);
    repeat (4) @(posedge ref_clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pwr_good = 1'b0;
    pad_in = 1'b1;
    spread_en_n = 1'b0;
    t_reset();
    t_window(1'b1);
    t_clock_out();
    t_frozen();
    t_spread();
    t_power_loss();
    t_window(1'b0);   // R7 fresh window latches the other level
    t_clock_out();
    t_frozen();
    t_spread();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule